// File: doc/BRIEF.md
# Hybrid Direct/Serial State-Access Tree

This block gives a single 64-bit access port reach into a large pool of state segments. Each segment is wider than the port. A request carries an address that is split in two. The segment index picks one leaf through a registered tree in which every node has four branches. The slice index picks one 64-bit slice inside that leaf's segment. Inside the leaf the segment is copied into a rotating buffer. The buffer turns one slice per clock, so the wanted slice passes the low end of the buffer after as many shifts as its index.

The buffer always makes a full turn. It ends in its original alignment, so a write can hand the whole segment back to its state flops as one parallel update. Those state flops sit outside the block. The leaf only samples the segment bus when a request arrives and raises a one-cycle write strobe when it commits. Segments that are not addressed are never touched. Any wide parallel operation on the state flops therefore proceeds without interference.

Only one request is outstanding at a time. Software-visible latency grows with the slice index, while the wiring from root to leaf stays one word wide.

Top module: `sat_tree`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready_o` is 1, `rsp_done_o` is 0, `rsp_rdata_o` is 0 and every bit of `seg_we_o` is 0.
- R2: The address field `req_addr_i[8:3]` selects the segment and `req_addr_i[2:0]` selects the slice. A read of slice k in segment s returns bits [64k+63:64k] of segment s as presented on `seg_state_i[s*512 +: 512]`.
- R3: For a read of slice k, `rsp_done_o` is high in the cycle after the (LEVELS+1+k)-th rising edge that follows the accepting edge. With the default values this is edge 4+k. `rsp_rdata_o` carries the result in that same cycle.
- R4: For a write to slice k of segment s, `seg_we_o[s]` is high for exactly one cycle, the cycle after edge LEVELS+SLICES (11). In that cycle `seg_wdata_o` for segment s equals the segment's prior state with only slice k replaced by the write data, and every other slice is in its original position.
- R5: A write reports `rsp_done_o` in the cycle after edge LEVELS+SLICES+1 (12), directly after its commit strobe.
- R6: At most one `seg_we_o` bit is high at any time. It is only ever the addressed segment's bit, and a read raises none.
- R7: `req_ready_o` drops after the accepting edge and returns in the cycle after edge LEVELS+SLICES+1 (12), for reads and writes alike. A request presented while `req_ready_o` is low is ignored: it causes no strobe and no done pulse.
- R8: Each accepted request produces exactly one `rsp_done_o` pulse, and that pulse lasts one cycle.
- R9: `rsp_rdata_o` changes only in a cycle where a read reports done. It holds its value across writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 9 | Segment index (upper 6) and slice index (lower 3) |
| req_wdata_i | input | 64 | Write data for the slice |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 64 | Read data, held between reads |
| seg_state_i | input | 32768 | Current content of every segment, segment s at s*512 |
| seg_we_o | output | 64 | Per-segment commit strobe |
| seg_wdata_o | output | 32768 | Per-segment updated content, segment s at s*512 |

## Verification
The bench builds the tree with its default values: 64-bit data, eight slices per segment and three levels of four-way nodes, giving 64 leaves. These values make both corners of the address space reachable, segments 0 and 63 and slices 0 and 7. The latency spread from 4 to 11 cycles can then be measured directly against the slice index. Because every segment has its own strobe, a stray commit in any of the 64 leaves is visible at the ports. The bench's own model of the state flops is fed back into the tree, so a write that is read back afterwards tests the full round trip through the rotation.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int unsigned SAT_DATA_W = 64;
    localparam int unsigned SAT_SLICES = 8;
    localparam int unsigned SAT_LEVELS = 3;
    localparam int unsigned SAT_BR_W   = 2;
    localparam int unsigned SAT_BR_N   = 1 << SAT_BR_W;

    typedef enum logic [1:0] {
        LF_IDLE = 2'd0,
        LF_ROT  = 2'd1,
        LF_FIN  = 2'd2
    } leaf_st_e;

    function automatic int unsigned pow4(input int unsigned l);
        int unsigned p;
        p = 1;
        for (int unsigned i = 0; i < l; i++) p = p * SAT_BR_N;
        return p;
    endfunction

    // index of the first node of tree level l in a flat node array
    function automatic int unsigned lvl_base(input int unsigned l);
        int unsigned b;
        b = 0;
        for (int unsigned i = 0; i < l; i++) b = b + pow4(i);
        return b;
    endfunction

endpackage

// File: rtl/sat_node.sv
module sat_node
    import sat_pkg::*;
#(
    parameter int unsigned DATA_W    = SAT_DATA_W,
    parameter int unsigned SLICE_W   = 3,
    parameter int unsigned SEG_IDX_W = 6,
    parameter int unsigned LEVEL     = 0,
    localparam int unsigned REQ_W    = 1 + SEG_IDX_W + SLICE_W + DATA_W,
    localparam int unsigned SEL_LSB  = DATA_W + SLICE_W + SEG_IDX_W - SAT_BR_W * (LEVEL + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_v,
    input  logic [REQ_W-1:0]             in_req,
    output logic [SAT_BR_N-1:0]          out_v,
    output logic [REQ_W-1:0]             out_req,
    input  logic [SAT_BR_N-1:0]          child_v,
    input  logic [SAT_BR_N-1:0]          child_fin,
    input  logic [SAT_BR_N*DATA_W-1:0]   child_data,
    output logic                         rsp_v,
    output logic                         rsp_fin,
    output logic [DATA_W-1:0]            rsp_data
);

    logic               v_q;
    logic [REQ_W-1:0]   req_q;
    logic [SAT_BR_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
        end else begin
            v_q <= in_v;
        end
        if (in_v) req_q <= in_req;
    end

    assign sel     = req_q[SEL_LSB +: SAT_BR_W];
    assign out_req = req_q;

    always_comb begin
        for (int c = 0; c < SAT_BR_N; c++) begin
            out_v[c] = v_q && (sel == SAT_BR_W'(c));
        end
    end

    // response path is unregistered: leaves zero their data when silent
    always_comb begin
        rsp_data = '0;
        for (int c = 0; c < SAT_BR_N; c++) begin
            rsp_data = rsp_data | child_data[c*DATA_W +: DATA_W];
        end
    end

    assign rsp_v   = |child_v;
    assign rsp_fin = |child_fin;

endmodule

// File: rtl/sat_leaf.sv
module sat_leaf
    import sat_pkg::*;
#(
    parameter int unsigned DATA_W    = SAT_DATA_W,
    parameter int unsigned SLICES    = SAT_SLICES,
    parameter int unsigned SEG_IDX_W = 6,
    parameter int unsigned IDX       = 0,
    localparam int unsigned SLICE_W  = $clog2(SLICES),
    localparam int unsigned SEG_W    = DATA_W * SLICES,
    localparam int unsigned REQ_W    = 1 + SEG_IDX_W + SLICE_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_v,
    input  logic [REQ_W-1:0]   in_req,
    input  logic [SEG_W-1:0]   seg_state_i,
    output logic               seg_we_o,
    output logic [SEG_W-1:0]   seg_wdata_o,
    output logic               rsp_v,
    output logic               rsp_fin,
    output logic [DATA_W-1:0]  rsp_data
);

    typedef struct packed {
        logic                 we;
        logic [SEG_IDX_W-1:0] seg;
        logic [SLICE_W-1:0]   slice;
        logic [DATA_W-1:0]    wdata;
    } req_t;

    req_t               rin;
    req_t               rq;
    leaf_st_e           st;
    logic [SLICE_W-1:0] cnt;
    logic [SEG_W-1:0]   ring;
    logic [SEG_W-1:0]   patched;
    logic               go;
    logic               hit;

    assign rin = req_t'(in_req);
    assign go  = in_v && (rin.seg == SEG_IDX_W'(IDX));
    assign hit = (st == LF_ROT) && (cnt == rq.slice);

    always_comb begin
        patched = ring;
        if (hit && rq.we) patched[DATA_W-1:0] = rq.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= LF_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                LF_IDLE: begin
                    if (go) begin
                        st   <= LF_ROT;
                        cnt  <= '0;
                        ring <= seg_state_i;
                        rq   <= rin;
                    end
                end
                LF_ROT: begin
                    ring <= {patched[DATA_W-1:0], patched[SEG_W-1:DATA_W]};
                    cnt  <= cnt + SLICE_W'(1);
                    if (cnt == SLICE_W'(SLICES - 1)) st <= LF_FIN;
                end
                LF_FIN:  st <= LF_IDLE;
                default: st <= LF_IDLE;
            endcase
        end
    end

    assign seg_we_o    = (st == LF_FIN) && rq.we;
    assign seg_wdata_o = ring;
    assign rsp_fin     = (st == LF_FIN);
    assign rsp_v       = (hit && !rq.we) || seg_we_o;
    assign rsp_data    = (hit && !rq.we) ? ring[DATA_W-1:0] : '0;

endmodule

// File: rtl/sat_tree.sv
module sat_tree
    import sat_pkg::*;
#(
    parameter int unsigned DATA_W    = SAT_DATA_W,
    parameter int unsigned SLICES    = SAT_SLICES,
    parameter int unsigned LEVELS    = SAT_LEVELS,
    localparam int unsigned SLICE_W  = $clog2(SLICES),
    localparam int unsigned SEG_IDX_W = SAT_BR_W * LEVELS,
    localparam int unsigned SEGS     = 1 << SEG_IDX_W,
    localparam int unsigned SEG_W    = DATA_W * SLICES,
    localparam int unsigned ADDR_W   = SEG_IDX_W + SLICE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid_i,
    output logic                    req_ready_o,
    input  logic                    req_write_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic [DATA_W-1:0]       req_wdata_i,
    output logic                    rsp_done_o,
    output logic [DATA_W-1:0]       rsp_rdata_o,
    input  logic [SEGS*SEG_W-1:0]   seg_state_i,
    output logic [SEGS-1:0]         seg_we_o,
    output logic [SEGS*SEG_W-1:0]   seg_wdata_o
);

    localparam int unsigned REQ_W  = 1 + SEG_IDX_W + SLICE_W + DATA_W;
    localparam int unsigned N_NODE = lvl_base(LEVELS);

    logic                 node_in_v    [N_NODE];
    logic [REQ_W-1:0]     node_in_req  [N_NODE];
    logic [SAT_BR_N-1:0]  node_out_v   [N_NODE];
    logic [REQ_W-1:0]     node_out_req [N_NODE];
    logic                 node_rsp_v   [N_NODE];
    logic                 node_rsp_fin [N_NODE];
    logic [DATA_W-1:0]    node_rsp_data[N_NODE];

    logic                 leaf_in_v    [SEGS];
    logic [REQ_W-1:0]     leaf_in_req  [SEGS];
    logic                 leaf_rsp_v   [SEGS];
    logic                 leaf_rsp_fin [SEGS];
    logic [DATA_W-1:0]    leaf_rsp_data[SEGS];

    logic busy;
    logic wr_q;
    logic accept;

    // ---------------- root control ----------------
    assign accept      = req_valid_i && !busy;
    assign req_ready_o = !busy;

    assign node_in_v[0]   = accept;
    assign node_in_req[0] = {req_write_i, req_addr_i, req_wdata_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            wr_q        <= 1'b0;
            rsp_done_o  <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_done_o <= node_rsp_v[0];
            if (node_rsp_v[0] && !wr_q) rsp_rdata_o <= node_rsp_data[0];
            if (accept) begin
                busy <= 1'b1;
                wr_q <= req_write_i;
            end else if (node_rsp_fin[0]) begin
                busy <= 1'b0;
            end
        end
    end

    // ---------------- routing tree ----------------
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar j = 0; j < pow4(l); j++) begin : g_node
            localparam int unsigned G = lvl_base(l) + j;
            logic [SAT_BR_N-1:0]        cv;
            logic [SAT_BR_N-1:0]        cf;
            logic [SAT_BR_N*DATA_W-1:0] cd;

            sat_node #(
                .DATA_W   (DATA_W),
                .SLICE_W  (SLICE_W),
                .SEG_IDX_W(SEG_IDX_W),
                .LEVEL    (l)
            ) u_node (
                .clk       (clk),
                .rst       (rst),
                .in_v      (node_in_v[G]),
                .in_req    (node_in_req[G]),
                .out_v     (node_out_v[G]),
                .out_req   (node_out_req[G]),
                .child_v   (cv),
                .child_fin (cf),
                .child_data(cd),
                .rsp_v     (node_rsp_v[G]),
                .rsp_fin   (node_rsp_fin[G]),
                .rsp_data  (node_rsp_data[G])
            );

            for (genvar c = 0; c < SAT_BR_N; c++) begin : g_br
                if (l < LEVELS - 1) begin : g_inner
                    localparam int unsigned CG = lvl_base(l + 1) + SAT_BR_N * j + c;
                    assign node_in_v[CG]          = node_out_v[G][c];
                    assign node_in_req[CG]        = node_out_req[G];
                    assign cv[c]                  = node_rsp_v[CG];
                    assign cf[c]                  = node_rsp_fin[CG];
                    assign cd[c*DATA_W +: DATA_W] = node_rsp_data[CG];
                end else begin : g_edge
                    localparam int unsigned LI = SAT_BR_N * j + c;
                    assign leaf_in_v[LI]          = node_out_v[G][c];
                    assign leaf_in_req[LI]        = node_out_req[G];
                    assign cv[c]                  = leaf_rsp_v[LI];
                    assign cf[c]                  = leaf_rsp_fin[LI];
                    assign cd[c*DATA_W +: DATA_W] = leaf_rsp_data[LI];
                end
            end
        end
    end

    // ---------------- serial leaves ----------------
    for (genvar s = 0; s < SEGS; s++) begin : g_leaf
        sat_leaf #(
            .DATA_W   (DATA_W),
            .SLICES   (SLICES),
            .SEG_IDX_W(SEG_IDX_W),
            .IDX      (s)
        ) u_leaf (
            .clk        (clk),
            .rst        (rst),
            .in_v       (leaf_in_v[s]),
            .in_req     (leaf_in_req[s]),
            .seg_state_i(seg_state_i[s*SEG_W +: SEG_W]),
            .seg_we_o   (seg_we_o[s]),
            .seg_wdata_o(seg_wdata_o[s*SEG_W +: SEG_W]),
            .rsp_v      (leaf_rsp_v[s]),
            .rsp_fin    (leaf_rsp_fin[s]),
            .rsp_data   (leaf_rsp_data[s])
        );
    end

endmodule

// File: rtl/sat_tree_chk.sv
module sat_tree_chk #(
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned SLICES    = 8,
    parameter int unsigned LEVELS    = 3,
    localparam int unsigned SLICE_W  = $clog2(SLICES),
    localparam int unsigned SEG_IDX_W = 2 * LEVELS,
    localparam int unsigned SEGS     = 1 << SEG_IDX_W,
    localparam int unsigned SEG_W    = DATA_W * SLICES,
    localparam int unsigned ADDR_W   = SEG_IDX_W + SLICE_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid_i,
    input logic                  req_ready_o,
    input logic                  req_write_i,
    input logic [ADDR_W-1:0]     req_addr_i,
    input logic [DATA_W-1:0]     req_wdata_i,
    input logic                  rsp_done_o,
    input logic [DATA_W-1:0]     rsp_rdata_o,
    input logic [SEGS*SEG_W-1:0] seg_state_i,
    input logic [SEGS-1:0]       seg_we_o,
    input logic [SEGS*SEG_W-1:0] seg_wdata_o
);

    AST_SEG_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(seg_we_o)); // R6

    AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        req_ready_o |-> (seg_we_o == '0)); // R6

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !req_ready_o); // R7

    AST_COMMIT_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        (|seg_we_o) |=> (rsp_done_o && req_ready_o)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done_o |=> !rsp_done_o); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rsp_done_o |-> $stable(rsp_rdata_o)); // R9

endmodule

bind sat_tree sat_tree_chk #(
    .DATA_W(DATA_W),
    .SLICES(SLICES),
    .LEVELS(LEVELS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .rsp_done_o (rsp_done_o),
    .rsp_rdata_o(rsp_rdata_o),
    .seg_state_i(seg_state_i),
    .seg_we_o   (seg_we_o),
    .seg_wdata_o(seg_wdata_o)
);

// File: tb/tb_sat_tree.sv
`timescale 1ns/1ps
module tb_sat_tree;

    localparam int DATA_W  = 64;
    localparam int SLICES  = 8;
    localparam int LEVELS  = 3;
    localparam int SLICE_W = 3;
    localparam int SEGS    = 64;
    localparam int SEG_W   = DATA_W * SLICES;
    localparam int ADDR_W  = 9;
    localparam int RD_BASE = LEVELS + 1;        // read done edge = 4 + slice
    localparam int WE_EDGE = LEVELS + SLICES;   // 11
    localparam int FIN_EDGE = LEVELS + SLICES + 1; // 12

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  req_valid = 1'b0;
    logic                  req_ready;
    logic                  req_write = 1'b0;
    logic [ADDR_W-1:0]     req_addr = '0;
    logic [DATA_W-1:0]     req_wdata = '0;
    logic                  rsp_done;
    logic [DATA_W-1:0]     rsp_rdata;
    logic [SEGS*SEG_W-1:0] seg_state;
    logic [SEGS-1:0]       seg_we;
    logic [SEGS*SEG_W-1:0] seg_wdata;

    always #2.5 clk = ~clk;

    sat_tree #(.DATA_W(DATA_W), .SLICES(SLICES), .LEVELS(LEVELS)) dut (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
        .seg_state_i(seg_state), .seg_we_o(seg_we), .seg_wdata_o(seg_wdata)
    );

    function automatic logic [DATA_W-1:0] init_slice(input int s, input int k);
        return {8'(s), 8'(k), 16'hBEEF, 32'(s * 131 + k * 977 + 5)};
    endfunction

    function automatic logic [SEG_W-1:0] init_seg(input int s);
        logic [SEG_W-1:0] v;
        for (int k = 0; k < SLICES; k++) v[k*DATA_W +: DATA_W] = init_slice(s, k);
        return v;
    endfunction

    // state flops outside the block, written back by the commit strobe
    logic [SEG_W-1:0] mem [SEGS];
    logic [SEG_W-1:0] ref_mem [SEGS];

    always @(posedge clk) begin
        for (int s = 0; s < SEGS; s++) begin
            if (rst) mem[s] <= init_seg(s);
            else if (seg_we[s]) mem[s] <= seg_wdata[s*SEG_W +: SEG_W];
        end
    end

    always_comb begin
        for (int s = 0; s < SEGS; s++) seg_state[s*SEG_W +: SEG_W] = mem[s];
    end

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [SEG_W-1:0] act,
                       input logic [SEG_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // observation results of one request window
    int               o_done_cnt, o_done_n, o_we_cnt, o_we_seg, o_we_n;
    logic [DATA_W-1:0] o_rdata;
    logic [SEG_W-1:0]  o_we_data;
    bit               o_rdy_pre, o_rdy11, o_rdy12;

    task automatic run_req(input bit we, input int seg, input int sl,
                           input logic [DATA_W-1:0] wd, input bit intr, input int intr_seg);
        @(negedge clk);
        o_rdy_pre = req_ready;
        req_valid = 1'b1;
        req_write = we;
        req_addr  = ADDR_W'(seg * SLICES + sl);
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        if (intr) begin
            req_write = 1'b1;
            req_addr  = ADDR_W'(intr_seg * SLICES + 2);
            req_wdata = 64'hDEAD_DEAD_DEAD_DEAD;
        end else begin
            req_valid = 1'b0;
        end
        o_done_cnt = 0; o_done_n = -1; o_we_cnt = 0; o_we_seg = -1; o_we_n = -1;
        o_rdata = '0; o_we_data = '0; o_rdy11 = 1'b0; o_rdy12 = 1'b0;
        for (int n = 1; n <= 14; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 4) req_valid = 1'b0;
            if (rsp_done) begin
                o_done_cnt++;
                if (o_done_n < 0) begin
                    o_done_n = n;
                    o_rdata  = rsp_rdata;
                end
            end
            for (int s = 0; s < SEGS; s++) begin
                if (seg_we[s]) begin
                    o_we_cnt++;
                    o_we_seg  = s;
                    o_we_n    = n;
                    o_we_data = seg_wdata[s*SEG_W +: SEG_W];
                end
            end
            if (n == WE_EDGE) o_rdy11 = req_ready;
            if (n == FIN_EDGE) o_rdy12 = req_ready;
        end
    endtask

    task automatic test_reset();
        chk(req_ready == 1'b1, "R1 ready after reset", SEG_W'(req_ready), 1);
        chk(rsp_done == 1'b0, "R1 done after reset", SEG_W'(rsp_done), 0);
        chk(rsp_rdata == '0, "R1 rdata after reset", SEG_W'(rsp_rdata), 0);
        chk(seg_we == '0, "R1 strobes after reset", SEG_W'(seg_we), 0);
    endtask

    task automatic test_read(input int seg, input int sl);
        logic [DATA_W-1:0] exp;
        exp = ref_mem[seg][sl*DATA_W +: DATA_W];
        run_req(1'b0, seg, sl, '0, 1'b0, 0);
        chk(o_rdy_pre, "R7 ready before read", SEG_W'(o_rdy_pre), 1);
        chk(o_rdata == exp, "R2 read data", SEG_W'(o_rdata), SEG_W'(exp));
        chk(o_done_n == RD_BASE + sl, "R3 read latency", SEG_W'(o_done_n), SEG_W'(RD_BASE + sl));
        chk(o_done_cnt == 1, "R8 one done per read", SEG_W'(o_done_cnt), 1);
        chk(o_we_cnt == 0, "R6 read raises no strobe", SEG_W'(o_we_cnt), 0);
        chk(!o_rdy11 && o_rdy12, "R7 ready window on read", SEG_W'({o_rdy11, o_rdy12}), 1);
    endtask

    task automatic test_write(input int seg, input int sl, input logic [DATA_W-1:0] wd);
        logic [SEG_W-1:0]  exp;
        logic [DATA_W-1:0] prev_rdata;
        exp = ref_mem[seg];
        exp[sl*DATA_W +: DATA_W] = wd;
        prev_rdata = rsp_rdata;
        run_req(1'b1, seg, sl, wd, 1'b0, 0);
        chk(o_we_cnt == 1, "R4 single strobe", SEG_W'(o_we_cnt), 1);
        chk(o_we_seg == seg, "R6 strobe on addressed segment", SEG_W'(o_we_seg), SEG_W'(seg));
        chk(o_we_n == WE_EDGE, "R4 strobe cycle", SEG_W'(o_we_n), SEG_W'(WE_EDGE));
        chk(o_we_data == exp, "R4 committed segment aligned", o_we_data, exp);
        chk(o_done_n == FIN_EDGE, "R5 write done cycle", SEG_W'(o_done_n), SEG_W'(FIN_EDGE));
        chk(o_done_cnt == 1, "R8 one done per write", SEG_W'(o_done_cnt), 1);
        chk(rsp_rdata == prev_rdata, "R9 rdata held over write", SEG_W'(rsp_rdata), SEG_W'(prev_rdata));
        chk(!o_rdy11 && o_rdy12, "R7 ready window on write", SEG_W'({o_rdy11, o_rdy12}), 1);
        ref_mem[seg] = exp;
        test_read(seg, sl);
        if (sl != 0) test_read(seg, 0);
    endtask

    task automatic test_busy_ignored();
        run_req(1'b0, 9, 2, '0, 1'b1, 10);
        chk(o_we_cnt == 0, "R7 request while busy makes no strobe", SEG_W'(o_we_cnt), 0);
        chk(o_done_cnt == 1, "R7 request while busy makes no done", SEG_W'(o_done_cnt), 1);
        chk(o_rdata == ref_mem[9][2*DATA_W +: DATA_W], "R2 read under contention",
            SEG_W'(o_rdata), SEG_W'(ref_mem[9][2*DATA_W +: DATA_W]));
        test_read(10, 2);
    endtask

    initial begin
        for (int s = 0; s < SEGS; s++) ref_mem[s] = init_seg(s);
        repeat (4) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        test_reset();
        test_read(0, 0);
        test_read(21, 3);
        test_read(63, 7);
        test_read(42, 5);
        test_write(5, 0, 64'h0123_4567_89AB_CDEF);
        test_write(63, 7, 64'hFEDC_BA98_7654_3210);
        test_write(17, 4, 64'hA5A5_5A5A_F0F0_0F0F);
        test_busy_ignored();
        test_read(4, 1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule